// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block serialises and deserialises asynchronous serial characters. The transmit side takes one byte at a time through a ready/valid handshake and drives the serial output line. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The receive side watches the serial input line, recovers each character, and hands it out with a one-cycle valid strobe. Parity-error and frame-error flags travel with the strobe.

Both directions run from a single-cycle oversampling tick supplied by the surrounding baud logic. One bit period lasts `OSR` ticks. The receiver takes three samples around the middle of each bit and resolves them by majority vote. An optional mode makes the receiver also sample the line on the falling clock edge. Framing and parity settings are plain configuration inputs and are expected to be held steady while a frame is in flight.

Top module: `uart_frame_engine`

## Requirements
- R1: Out of reset `txd` is high, `tx_ready` is 1, `tx_busy`, `rx_busy` and `rx_valid` are 0, and `txd` stays high whenever `tx_busy` is 0.
- R2: A byte accepted on `tx_valid`&&`tx_ready` is sent as a low start bit and then the data bits, least significant bit first. Each bit lasts `OSR` ticks. The count of data bits follows `char_sel`: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: With `par_on`=1 a parity bit follows the data bits. Let c be the number of data bits equal to 1 (or equal to 0 when `par_zero`=1). The parity bit is (c mod 2) XOR `par_odd`.
- R4: The transmitter ends each frame with high stop bits: one when `stop_two`=0, two when `stop_two`=1. `tx_busy` stays high until the last stop bit has finished.
- R5: `tx_ready` is low for the whole frame, so `tx_valid` has no effect while a frame is being sent.
- R6: The receiver delivers each character in `rx_byte` with `rx_valid` high for exactly one cycle. The data is placed least significant bit first, and bits above the character size are 0.
- R7: `rx_perr` is 1 when parity is on and the received parity bit differs from the R3 value for the received data. It is always 0 when parity is off.
- R8: If the first stop bit resolves low, `rx_ferr` is set and the received data is still delivered.
- R9: A start bit that resolves high at mid-bit is dropped. No character is delivered and `rx_busy` returns to 0.
- R10: Each received bit is the majority of three samples taken around mid-bit, so a single disagreeing sample does not change the data. When `strict_frm`=1, any data or parity bit whose three samples disagree also sets `rx_ferr`.
- R11: With `rx_dual`=1 the line is taken as low if either the rising-edge or the falling-edge sample is low. Clean frames are still received correctly.
- R12: `rx_busy` is high from start detection until the character is delivered, and it is 0 in the cycle `rx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, one cycle wide |
| char_sel | input | 2 | Character size code (5 to 8 bits) |
| par_on | input | 1 | Parity enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| par_zero | input | 1 | Parity counts zero bits when 1, one bits when 0 |
| stop_two | input | 1 | Two stop bits on transmit when 1 |
| strict_frm | input | 1 | Frame-error check on data and parity bits |
| rx_dual | input | 1 | Dual-edge receive sampling |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output line |
| tx_busy | output | 1 | Frame being sent |
| rxd | input | 1 | Serial input line |
| rx_byte | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_perr | output | 1 | Parity error for the delivered character |
| rx_ferr | output | 1 | Frame error for the delivered character |
| rx_busy | output | 1 | Receiver inside a frame |

## Verification
The bench builds the block with `OSR`=8 and pulses the tick every third clock. One bit is then 24 clocks, so a 12-bit frame finishes in under 300 cycles and every size, parity and stop combination fits in one short run. Three clocks per tick let the bench place a line glitch that lands on exactly one of the three mid-bit samples. This reaches the majority vote and the strict frame check deterministically, and it also makes the partial first bit after a handshake visible.

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [1:0] char_sel,
  input  logic       par_on,
  input  logic       par_odd,
  input  logic       par_zero,
  input  logic       stop_two,
  input  logic       strict_frm,
  input  logic       rx_dual,
  input  logic [7:0] tx_byte,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  output logic       tx_busy,
  input  logic       rxd,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_busy
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] V0 = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] V1 = CW'(OSR / 2);
  localparam logic [CW-1:0] V2 = CW'(OSR / 2 + 1);

  logic [3:0] nbits;
  logic [7:0] mask;
  assign nbits = 4'd5 + {2'b00, char_sel};
  assign mask  = ~(8'hFF << nbits);

  function automatic logic par_calc(input logic [7:0] d, input logic [7:0] m,
                                    input logic n_odd, input logic zero, input logic odd);
    return (^(d & m)) ^ (zero & n_odd) ^ odd;
  endfunction

  // transmitter
  logic [11:0]   tx_sh, tx_frame;
  logic [3:0]    tx_left, tx_total;
  logic [CW-1:0] tx_cnt;

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nbits) tx_frame[i+1] = tx_byte[i];
    if (par_on)
      tx_frame[4'd1 + nbits] = par_calc(tx_byte, mask, nbits[0], par_zero, par_odd);
  end
  assign tx_total = 4'd2 + nbits + {3'b000, par_on} + {3'b000, stop_two};
  assign tx_ready = ~tx_busy;
  assign txd      = tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (!tx_busy) begin
      if (tx_valid) begin
        tx_busy <= 1'b1;
        tx_sh   <= tx_frame;
        tx_left <= tx_total;
        tx_cnt  <= '0;
      end
    end else if (os_tick) begin
      if (tx_cnt == LAST) begin
        tx_cnt  <= '0;
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  // receiver input sampling
  logic rx_m, rx_s, rx_n, samp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_m, rx_s} <= 2'b11;
    else        {rx_m, rx_s} <= {rxd, rx_m};
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) rx_n <= 1'b1;
    else        rx_n <= rx_m;
  assign samp = rx_dual ? (rx_s & rx_n) : rx_s;

  // receiver
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx;
  logic [1:0]    votes;
  logic [7:0]    rx_sh;
  logic          rx_prev, rx_pbit, rx_noisy, bitv, unan;
  assign bitv = (votes[0] & votes[1]) | (votes[0] & samp) | (votes[1] & samp);
  assign unan = (votes[0] == votes[1]) && (votes[1] == samp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_valid <= 1'b0; rx_perr <= 1'b0; rx_ferr <= 1'b0;
      rx_byte <= '0;   rx_sh <= '0;      rx_cnt <= '0;    rx_idx <= '0;
      votes <= '0;     rx_prev <= 1'b1;  rx_pbit <= 1'b0; rx_noisy <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (os_tick) begin
        rx_prev <= samp;
        if (!rx_busy) begin
          if (rx_prev && !samp) begin
            rx_busy  <= 1'b1;
            rx_cnt   <= CW'(1);
            rx_idx   <= '0;
            rx_sh    <= '0;
            rx_noisy <= 1'b0;
          end
        end else begin
          rx_cnt <= (rx_cnt == LAST) ? '0 : rx_cnt + 1'b1;
          if (rx_cnt == LAST) rx_idx <= rx_idx + 4'd1;
          if (rx_cnt == V0) votes[0] <= samp;
          if (rx_cnt == V1) votes[1] <= samp;
          if (rx_cnt == V2) begin
            if (rx_idx == 4'd0) begin
              if (bitv) rx_busy <= 1'b0;
            end else if (rx_idx <= nbits) begin
              rx_sh[3'(rx_idx - 4'd1)] <= bitv;
              rx_noisy <= rx_noisy | (strict_frm & ~unan);
            end else if (par_on && rx_idx == nbits + 4'd1) begin
              rx_pbit  <= bitv;
              rx_noisy <= rx_noisy | (strict_frm & ~unan);
            end else begin
              rx_busy  <= 1'b0;
              rx_valid <= 1'b1;
              rx_byte  <= rx_sh;
              rx_perr  <= par_on & (rx_pbit != par_calc(rx_sh, mask, nbits[0], par_zero, par_odd));
              rx_ferr  <= ~bitv | rx_noisy;
            end
          end
        end
      end
    end
  end

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> txd);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> !txd);
  p_hold_bit_r2:  assert property (@(posedge clk) disable iff (!rst_n)
                                   (tx_busy && !os_tick) |=> $stable(txd));
  p_pulse_r6:     assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);
  p_perr_off_r7:  assert property (@(posedge clk) disable iff (!rst_n)
                                   (rx_valid && !par_on) |-> !rx_perr);
  p_busy_drop_r12: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> !rx_busy);
endmodule

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
  localparam int OSR = 8;
  localparam int BIT = OSR * 3;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
  logic [1:0] char_sel = 2'd3;
  logic par_on = 0, par_odd = 0, par_zero = 0, stop_two = 0, strict_frm = 0, rx_dual = 0;
  logic [7:0] tx_byte = '0;
  logic tx_valid = 0, rxd = 1'b1;
  logic tx_ready, txd, tx_busy, rx_valid, rx_perr, rx_ferr, rx_busy;
  logic [7:0] rx_byte;
  int tests = 0, fails = 0, cyc = 0, tdiv = 0;
  int got_n = 0; logic [7:0] got_b; logic got_p, got_f;

  uart_frame_engine #(.OSR(OSR)) uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .char_sel(char_sel), .par_on(par_on),
    .par_odd(par_odd), .par_zero(par_zero), .stop_two(stop_two), .strict_frm(strict_frm),
    .rx_dual(rx_dual), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .tx_busy(tx_busy), .rxd(rxd), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_busy(rx_busy));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    os_tick = (tdiv == 0);
    if (rx_valid) begin got_n++; got_b = rx_byte; got_p = rx_perr; got_f = rx_ferr; end
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: act %0d cycles, exp < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: act %0h exp %0h", req, act, exp); end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int nb, input bit z, input bit o);
    int c = 0;
    for (int i = 0; i < nb; i++) if (d[i] == !z) c++;
    return logic'(c % 2) ^ o;
  endfunction

  task automatic set_cfg(input logic [1:0] cs, input bit p, o, z, two, st, du);
    @(negedge clk);
    char_sel = cs; par_on = p; par_odd = o; par_zero = z; stop_two = two;
    strict_frm = st; rx_dual = du;
  endtask

  task automatic tx_case(input logic [1:0] cs, input bit p, o, z, two, input logic [7:0] d);
    int nb = 5 + int'(cs);
    int tot = 2 + nb + int'(p) + int'(two);
    logic [11:0] e = '1;
    e[0] = 1'b0;
    for (int i = 0; i < nb; i++) e[i+1] = d[i];
    if (p) e[nb+1] = exp_par(d, nb, z, o);
    set_cfg(cs, p, o, z, two, 0, 0);
    tx_byte = d; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    repeat (12) @(negedge clk);
    for (int k = 0; k < tot; k++) begin
      if (k <= nb) chk(txd == e[k], "R2 tx bit", txd, e[k]);
      else if (p && k == nb + 1) chk(txd == e[k], "R3 tx parity", txd, e[k]);
      else chk(txd == 1'b1, "R4 stop high", txd, 1);
      if (k == 1) begin
        tx_byte = ~d; tx_valid = 1'b1;
        chk(tx_ready == 1'b0, "R5 ready low in frame", tx_ready, 0);
      end
      if (k == 2) tx_valid = 1'b0;
      if (two && k == tot - 1) chk(tx_busy == 1'b1, "R4 busy in 2nd stop", tx_busy, 1);
      repeat (BIT) @(negedge clk);
    end
    if (!two) chk(tx_busy == 1'b0 && txd == 1'b1, "R4 one stop ends", tx_busy, 0);
    while (tx_busy) @(negedge clk);
  endtask

  task automatic rx_drive(input int nb, input bit p, input logic pb, input logic [7:0] d,
                          input logic stopv, input int gbit, output bit busy_mid);
    logic [11:0] b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < nb; i++) b[i+1] = d[i];
    if (p) b[nb+1] = pb;
    b[nb+1+int'(p)] = stopv;
    busy_mid = 1'b0;
    for (int k = 0; k < nb + 2 + int'(p); k++)
      for (int i = 0; i < BIT; i++) begin
        rxd = (k == gbit && i >= 12 && i < 15) ? ~b[k] : b[k];
        if (k == 1 && i == 12) busy_mid = rx_busy;
        @(negedge clk);
      end
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic rx_case(input string req, input logic [1:0] cs, input bit p, o, z,
                         input bit bad_par, input logic [7:0] d, input logic stopv,
                         input int gbit, input bit st, input bit du, input bit exp_f);
    int nb = 5 + int'(cs);
    int n0 = got_n;
    logic [7:0] m = 8'hFF >> (8 - nb);
    logic pb = exp_par(d & m, nb, z, o) ^ bad_par;
    bit bm;
    set_cfg(cs, p, o, z, 0, st, du);
    rx_drive(nb, p, pb, d, stopv, gbit, bm);
    chk(got_n == n0 + 1, {req, " R6 one strobe"}, got_n - n0, 1);
    chk(got_b == (d & m), {req, " R6 data"}, got_b, d & m);
    chk(got_p == (p & bad_par), {req, " R7 parity flag"}, got_p, p & bad_par);
    chk(got_f == exp_f, {req, " R8/R10 frame flag"}, got_f, exp_f);
    chk(bm == 1'b1, {req, " R12 busy in frame"}, bm, 1);
    chk(rx_busy == 1'b0, {req, " R12 idle after"}, rx_busy, 0);
  endtask

  task automatic reset_case;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_ready == 1'b1 && tx_busy == 1'b0, "R1 tx idle", {tx_ready, tx_busy}, 2);
    chk(rx_busy == 1'b0 && rx_valid == 1'b0, "R1 rx idle", {rx_busy, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic glitch_start_case;
    int n0 = got_n;
    set_cfg(2'd3, 0, 0, 0, 0, 0, 0);
    rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk(got_n == n0, "R9 no strobe on short start", got_n - n0, 0);
    chk(rx_busy == 1'b0, "R9 receiver back idle", rx_busy, 0);
  endtask

  initial begin
    reset_case();
    tx_case(2'd3, 0, 0, 0, 0, 8'hA6);
    tx_case(2'd0, 1, 0, 0, 1, 8'hF3);
    tx_case(2'd1, 1, 1, 0, 0, 8'h2D);
    tx_case(2'd2, 1, 0, 1, 1, 8'h55);
    tx_case(2'd0, 1, 1, 1, 0, 8'h09);
    rx_case("8N1", 2'd3, 0, 0, 0, 0, 8'hC5, 1'b1, -1, 0, 0, 0);
    rx_case("5-bit", 2'd0, 0, 0, 0, 0, 8'hFF, 1'b1, -1, 0, 0, 0);
    rx_case("7 even", 2'd2, 1, 0, 0, 0, 8'h6B, 1'b1, -1, 0, 0, 0);
    rx_case("6 zeros odd", 2'd1, 1, 1, 1, 0, 8'h15, 1'b1, -1, 0, 0, 0);
    rx_case("R7 bad parity", 2'd3, 1, 1, 0, 1, 8'h81, 1'b1, -1, 0, 0, 0);
    rx_case("R8 stop low", 2'd3, 0, 0, 0, 0, 8'h3C, 1'b0, -1, 0, 0, 1);
    rx_case("R10 vote", 2'd3, 0, 0, 0, 0, 8'h5A, 1'b1, 3, 0, 0, 0);
    rx_case("R10 strict", 2'd3, 0, 0, 0, 0, 8'h5A, 1'b1, 3, 1, 0, 1);
    rx_case("R10 strict clean", 2'd3, 1, 0, 0, 0, 8'h77, 1'b1, -1, 1, 0, 0);
    rx_case("R11 dual edge", 2'd3, 1, 0, 0, 0, 8'hA5, 1'b1, -1, 0, 1, 0);
    glitch_start_case();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule